// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a USB control transfer on endpoint 0 from the device side. It watches tokens that a serial interface engine has already decoded. For each token that is addressed to this device and to endpoint 0, and that carries no error, it decides what the device answers. It moves the transfer through its stages: setup, an optional data stage, and the status stage. It also keeps the DATA0/DATA1 toggle.

Two fields of the already parsed device request steer the block: the transfer direction, and whether a data stage exists. A token that runs against the request's direction is taken as the status stage. The status stage does not finish until the CPU has raised its end-of-packet strobe. Until then the host gets NAK and the transfer stays open. Each answer is a one-cycle transmit request carrying a response code, for the serializer to send.

Top module: `ep0_ctl_seq`

## Requirements
- R1: A hit SETUP token (tok_kind 2) sets `stage` to 1 and `toggle` to 1 one cycle later, from any stage, and pulses `ep0_irq`; it sends nothing.
- R2: A token is ignored when its address differs from `dev_addr`, its endpoint is not 0, or `tok_err` is set: no transmit, no interrupt, and `stage` and `toggle` keep their values.
- R3: For a request with the read direction (`req_dir_in`=1) and a data stage, an IN token (tok_kind 1) in stage 1 or 2 sets `stage` to 2 and sends DATA0 (tx_pid 0) when `toggle` is 0, or DATA1 (tx_pid 1) when it is 1. A following host ACK (tok_kind 3) inverts `toggle`; an ACK with no packet outstanding changes nothing.
- R4: For a request with the write direction and a data stage, an OUT token (tok_kind 0) in stage 1 or 2 sets `stage` to 2 and inverts `toggle`, with no transmit.
- R5: The status stage (`stage` 3) is entered on an OUT token for a read request that has data, and on an IN token otherwise. An OUT token for a write request with no data stage is ignored.
- R6: In the IN status stage, when end-of-packet is pending, the block sends DATA1 (tx_pid 1) with `tx_zlp`=1. The following ACK sets `stage` to 0 and pulses `ep0_irq`. When end-of-packet is not pending it sends NAK (tx_pid 2) and keeps `stage` at 3.
- R7: In the OUT status stage, when end-of-packet is pending, `stage` goes to 0 and `ep0_irq` pulses, with no transmit. When it is not pending the block sends NAK.
- R8: While `stall_en` is high, a hit IN or OUT token outside stage 0 sends STALL (tx_pid 3) and leaves `stage` unchanged. SETUP tokens are still accepted.
- R9: A `cpu_eop` pulse is held until a SETUP token or the completion of the status stage clears it. A pulse seen before a SETUP does not count for that transfer.
- R10: Every response appears on `tx_req` in the cycle after the token and lasts exactly one cycle.
- R11: After reset, `stage` is 0, `toggle` is 0, and `tx_req` and `ep0_irq` are low.
- R12: A hit IN or OUT token in stage 0 gets no response and leaves `stage` at 0, even while `stall_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Decoded token strobe |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 host ACK |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| tok_err | input | 1 | Token failed its checks |
| dev_addr | input | 7 | This device's address |
| req_dir_in | input | 1 | Request direction: 1 device-to-host |
| req_has_data | input | 1 | Request has a data stage |
| cpu_eop | input | 1 | CPU end-of-packet strobe for endpoint 0 |
| stall_en | input | 1 | Endpoint 0 stall condition |
| tx_req | output | 1 | Transmit request pulse |
| tx_pid | output | 2 | 0 DATA0, 1 DATA1, 2 NAK, 3 STALL |
| tx_zlp | output | 1 | Packet is the zero-length status packet |
| toggle | output | 1 | Current data toggle |
| stage | output | 2 | 0 idle, 1 setup, 2 data, 3 status |
| ep0_irq | output | 1 | Endpoint 0 stage event pulse |

## Verification
The bench runs read, write and no-data transfers, and checks each answer in the cycle after its token. An internal state that goes wrong shows at the ports within one token. A wrong stage shows as an unexpected answer, a missing NAK or a missing completion interrupt. A lost toggle inversion shows as the wrong DATA0/DATA1 code on the next IN. A leaked end-of-packet flag shows as a zero-length packet where NAK was due. The other runs send stray ACKs, foreign tokens, a stall, and SETUPs that abort a transfer; each one must leave the toggle and stage exactly where the requirements put them.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
  typedef enum logic [1:0] {TK_OUT = 2'd0, TK_IN = 2'd1, TK_SETUP = 2'd2, TK_ACK = 2'd3} tok_kind_e;
  typedef enum logic [1:0] {PID_DATA0 = 2'd0, PID_DATA1 = 2'd1, PID_NAK = 2'd2, PID_STALL = 2'd3} rsp_pid_e;
  typedef enum logic [1:0] {STG_IDLE = 2'd0, STG_SETUP = 2'd1, STG_DATA = 2'd2, STG_STATUS = 2'd3} stage_e;
  typedef enum logic [1:0] {AW_NONE = 2'd0, AW_DATA = 2'd1, AW_STATUS = 2'd2} await_e;
  localparam int NUM_KINDS = 4;
endpackage

// File: rtl/ep0_tok_filter.sv
module ep0_tok_filter
  import ep0_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int EP_NUM = 0
) (
  input  logic                 tok_valid,
  input  logic [1:0]           tok_kind,
  input  logic [ADDR_W-1:0]    tok_addr,
  input  logic [EP_W-1:0]      tok_ep,
  input  logic                 tok_err,
  input  logic [ADDR_W-1:0]    dev_addr,
  output logic [NUM_KINDS-1:0] hit_vec
);
  logic match;

  // A token counts only if it is addressed to this device and endpoint and is clean
  assign match = tok_valid && (tok_addr == dev_addr) && (tok_ep == EP_W'(EP_NUM)) && !tok_err;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign hit_vec[k] = match && (tok_kind == 2'(k));
  end
endmodule

// File: rtl/ep0_eop_flag.sv
module ep0_eop_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;
  logic flag_en;

  // Clear wins over a set that arrives in the same cycle
  always_comb begin
    flag_en = set_i || clr_i;
    flag_d  = !clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (flag_en) begin
      flag_o <= flag_d;
    end
  end
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_setup,
  input  logic       hit_in,
  input  logic       hit_out,
  input  logic       hit_ack,
  input  logic       req_dir_in,
  input  logic       req_has_data,
  input  logic       stall_en,
  input  logic       eop_flag,
  output logic       eop_clr,
  output logic       tx_req,
  output logic [1:0] tx_pid,
  output logic       tx_zlp,
  output logic       toggle,
  output logic [1:0] stage,
  output logic       irq
);
  stage_e   stage_q, stage_d;
  await_e   await_q, await_d;
  rsp_pid_e pid_q, pid_d;
  logic     tog_q, tog_d;
  logic     tx_req_q, tx_req_d;
  logic     zlp_q, zlp_d;
  logic     irq_q, irq_d;
  logic     hit_any, tok_io, status_is_in, is_status;

  assign hit_any      = hit_setup || hit_in || hit_out || hit_ack;
  assign tok_io       = hit_in || hit_out;
  // Status runs opposite to the data direction; with no data it is always IN
  assign status_is_in = !req_has_data || !req_dir_in;
  assign is_status    = hit_in ? status_is_in : !status_is_in;

  always_comb begin
    stage_d  = stage_q;
    tog_d    = tog_q;
    await_d  = hit_any ? AW_NONE : await_q;
    tx_req_d = 1'b0;
    pid_d    = PID_DATA0;
    zlp_d    = 1'b0;
    irq_d    = 1'b0;
    eop_clr  = 1'b0;
    if (hit_setup) begin
      stage_d = STG_SETUP;
      tog_d   = 1'b1;
      irq_d   = 1'b1;
      eop_clr = 1'b1;
    end else if (hit_ack) begin
      if (await_q == AW_DATA) begin
        tog_d = !tog_q;
      end else if (await_q == AW_STATUS) begin
        stage_d = STG_IDLE;
        irq_d   = 1'b1;
        eop_clr = 1'b1;
      end
    end else if (tok_io && (stage_q != STG_IDLE)) begin
      if (stall_en) begin
        tx_req_d = 1'b1;
        pid_d    = PID_STALL;
      end else if (is_status) begin
        stage_d = STG_STATUS;
        if (!eop_flag) begin
          tx_req_d = 1'b1;
          pid_d    = PID_NAK;
        end else if (hit_in) begin
          tx_req_d = 1'b1;
          pid_d    = PID_DATA1;
          zlp_d    = 1'b1;
          await_d  = AW_STATUS;
        end else begin
          stage_d = STG_IDLE;
          irq_d   = 1'b1;
          eop_clr = 1'b1;
        end
      end else if (req_has_data && (stage_q != STG_STATUS)) begin
        stage_d = STG_DATA;
        if (hit_in) begin
          tx_req_d = 1'b1;
          pid_d    = tog_q ? PID_DATA1 : PID_DATA0;
          await_d  = AW_DATA;
        end else begin
          tog_d = !tog_q;
        end
      end
    end
  end

  // Transfer state moves only on a hit token; response pulses update every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      tog_q   <= 1'b0;
      await_q <= AW_NONE;
    end else if (hit_any) begin
      stage_q <= stage_d;
      tog_q   <= tog_d;
      await_q <= await_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req_q <= 1'b0;
      pid_q    <= PID_DATA0;
      zlp_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      tx_req_q <= tx_req_d;
      pid_q    <= pid_d;
      zlp_q    <= zlp_d;
      irq_q    <= irq_d;
    end
  end

  assign tx_req = tx_req_q;
  assign tx_pid = pid_q;
  assign tx_zlp = zlp_q;
  assign toggle = tog_q;
  assign stage  = stage_q;
  assign irq    = irq_q;
endmodule

// File: rtl/ep0_ctl_seq.sv
module ep0_ctl_seq
  import ep0_seq_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int EP_NUM = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic [EP_W-1:0]   tok_ep,
  input  logic              tok_err,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              req_dir_in,
  input  logic              req_has_data,
  input  logic              cpu_eop,
  input  logic              stall_en,
  output logic              tx_req,
  output logic [1:0]        tx_pid,
  output logic              tx_zlp,
  output logic              toggle,
  output logic [1:0]        stage,
  output logic              ep0_irq
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [NUM_KINDS-1:0]   hit_vec;
  logic                   eop_flag;
  logic                   eop_clr;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  ep0_tok_filter #(.ADDR_W(ADDR_W), .EP_W(EP_W), .EP_NUM(EP_NUM)) u_filter (
    .tok_valid(tok_valid),
    .tok_kind (tok_kind),
    .tok_addr (tok_addr),
    .tok_ep   (tok_ep),
    .tok_err  (tok_err),
    .dev_addr (dev_addr),
    .hit_vec  (hit_vec)
  );

  ep0_eop_flag u_eop (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set_i (cpu_eop),
    .clr_i (eop_clr),
    .flag_o(eop_flag)
  );

  ep0_stage_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hit_setup   (hit_vec[TK_SETUP]),
    .hit_in      (hit_vec[TK_IN]),
    .hit_out     (hit_vec[TK_OUT]),
    .hit_ack     (hit_vec[TK_ACK]),
    .req_dir_in  (req_dir_in),
    .req_has_data(req_has_data),
    .stall_en    (stall_en),
    .eop_flag    (eop_flag),
    .eop_clr     (eop_clr),
    .tx_req      (tx_req),
    .tx_pid      (tx_pid),
    .tx_zlp      (tx_zlp),
    .toggle      (toggle),
    .stage       (stage),
    .irq         (ep0_irq)
  );
endmodule

// File: rtl/ep0_ctl_seq_chk.sv
module ep0_ctl_seq_chk #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int EP_NUM = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tok_valid,
  input logic [1:0]        tok_kind,
  input logic [ADDR_W-1:0] tok_addr,
  input logic [EP_W-1:0]   tok_ep,
  input logic              tok_err,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              stall_en,
  input logic              tx_req,
  input logic [1:0]        tx_pid,
  input logic              tx_zlp,
  input logic              toggle,
  input logic [1:0]        stage,
  input logic              ep0_irq
);
  logic hit;
  assign hit = tok_valid && (tok_addr == dev_addr) && (tok_ep == EP_W'(EP_NUM)) && !tok_err;

  assert_setup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit && (tok_kind == 2'd2) |=> (stage == 2'd1) && toggle && ep0_irq && !tx_req);

  assert_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !hit |=> !tx_req && !ep0_irq && $stable(stage) && $stable(toggle));

  assert_zlp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_zlp |-> tx_req && (tx_pid == 2'd1));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit && stall_en && !tok_kind[1] && (stage != 2'd0) |=> tx_req && (tx_pid == 2'd3) && $stable(stage));

  assert_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> $past(tok_valid));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !tok_kind[1] && (stage == 2'd0) |=> !tx_req && (stage == 2'd0));
endmodule

bind ep0_ctl_seq ep0_ctl_seq_chk #(.ADDR_W(ADDR_W), .EP_W(EP_W), .EP_NUM(EP_NUM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tok_valid(tok_valid),
  .tok_kind (tok_kind),
  .tok_addr (tok_addr),
  .tok_ep   (tok_ep),
  .tok_err  (tok_err),
  .dev_addr (dev_addr),
  .stall_en (stall_en),
  .tx_req   (tx_req),
  .tx_pid   (tx_pid),
  .tx_zlp   (tx_zlp),
  .toggle   (toggle),
  .stage    (stage),
  .ep0_irq  (ep0_irq)
);

// File: tb/ep0_ctl_seq_test.sv
module ep0_ctl_seq_test;
  localparam logic [6:0] DEV = 7'h15;
  localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2, K_ACK = 2'd3;
  localparam logic [1:0] P_D0 = 2'd0, P_D1 = 2'd1, P_NAK = 2'd2, P_STALL = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tok_valid, tok_err, req_dir_in, req_has_data, cpu_eop, stall_en;
  logic [1:0] tok_kind;
  logic [6:0] tok_addr, dev_addr;
  logic [3:0] tok_ep;
  logic       tx_req, tx_zlp, toggle, ep0_irq;
  logic [1:0] tx_pid, stage;

  int n_chk = 0;
  int n_fail = 0;
  logic run = 1'b0;
  logic done = 1'b0;

  logic [1:0] q_pid[$];
  logic       q_zlp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  ep0_ctl_seq uut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_err(tok_err), .dev_addr(dev_addr),
    .req_dir_in(req_dir_in), .req_has_data(req_has_data), .cpu_eop(cpu_eop),
    .stall_en(stall_en), .tx_req(tx_req), .tx_pid(tx_pid), .tx_zlp(tx_zlp),
    .toggle(toggle), .stage(stage), .ep0_irq(ep0_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_tx(input logic [1:0] pid, input logic zlp, input string tag);
    q_pid.push_back(pid);
    q_zlp.push_back(zlp);
    q_tag.push_back(tag);
  endtask

  // Returns at the falling edge after the capturing edge: responses are visible
  task automatic tok(input logic [1:0] kind, input logic [6:0] addr = DEV,
                     input logic [3:0] ep = 4'd0, input logic err = 1'b0);
    @(negedge clk);
    tok_valid = 1'b1; tok_kind = kind; tok_addr = addr; tok_ep = ep; tok_err = err;
    @(negedge clk);
    tok_valid = 1'b0; tok_err = 1'b0;
  endtask

  task automatic eop_pulse();
    @(negedge clk);
    cpu_eop = 1'b1;
    @(negedge clk);
    cpu_eop = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // Scoreboard monitor: every transmit must match the oldest expected item
  always @(negedge clk) begin
    #1;
    if (run && tx_req) begin
      n_chk++;
      if (q_pid.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected transmit actual=%0d expected=none", tx_pid);
      end else begin
        if (tx_pid !== q_pid[0] || tx_zlp !== q_zlp[0]) begin
          n_fail++;
          $display("FAIL %s actual=pid%0d/zlp%0d expected=pid%0d/zlp%0d",
                   q_tag[0], tx_pid, tx_zlp, q_pid[0], q_zlp[0]);
        end
        void'(q_pid.pop_front());
        void'(q_zlp.pop_front());
        void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tok_valid = 1'b0; tok_kind = 2'd0; tok_addr = DEV; tok_ep = 4'd0;
    tok_err = 1'b0; dev_addr = DEV; req_dir_in = 1'b1; req_has_data = 1'b1;
    cpu_eop = 1'b0; stall_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 stage", stage, 0);
    chk("R11 toggle", toggle, 0);
    chk("R11 tx_req", tx_req, 0);
    chk("R11 irq", ep0_irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b1;

    // R12: IN and OUT while idle, even with stall high
    stall_en = 1'b1;
    tok(K_IN);
    chk("R12 no tx", tx_req, 0);
    chk("R12 stage", stage, 0);
    stall_en = 1'b0;

    // Control read with data
    tok(K_SETUP);
    chk("R1 stage", stage, 1);
    chk("R1 toggle", toggle, 1);
    chk("R1 irq", ep0_irq, 1);
    expect_tx(P_D1, 1'b0, "R3 first IN DATA1");
    tok(K_IN);
    chk("R3 stage", stage, 2);
    @(negedge clk);
    chk("R10 one-cycle pulse", tx_req, 0);
    tok(K_ACK);
    chk("R3 toggle after ACK", toggle, 0);
    expect_tx(P_D0, 1'b0, "R3 second IN DATA0");
    tok(K_IN);
    tok(K_ACK);
    chk("R3 toggle second ACK", toggle, 1);
    tok(K_ACK);
    chk("R3 stray ACK", toggle, 1);
    tok(K_IN, 7'h16);
    chk("R2 addr no tx", tx_req, 0);
    tok(K_OUT, DEV, 4'd1);
    chk("R2 ep no tx", tx_req, 0);
    tok(K_SETUP, DEV, 4'd0, 1'b1);
    chk("R2 err irq", ep0_irq, 0);
    chk("R2 stage kept", stage, 2);
    chk("R2 toggle kept", toggle, 1);
    expect_tx(P_NAK, 1'b0, "R7 OUT status NAK");
    tok(K_OUT);
    chk("R5 read status stage", stage, 3);
    eop_pulse();
    tok(K_OUT);
    chk("R7 complete stage", stage, 0);
    chk("R7 complete irq", ep0_irq, 1);
    chk("R7 no tx", tx_req, 0);

    // Control write with data; early end-of-packet must not count
    req_dir_in = 1'b0;
    eop_pulse();
    tok(K_SETUP);
    tok(K_OUT);
    chk("R4 stage", stage, 2);
    chk("R4 toggle", toggle, 0);
    chk("R4 no tx", tx_req, 0);
    tok(K_OUT);
    chk("R4 toggle again", toggle, 1);
    expect_tx(P_NAK, 1'b0, "R9 eop cleared by SETUP");
    tok(K_IN);
    chk("R5 write status stage", stage, 3);
    eop_pulse();
    expect_tx(P_D1, 1'b1, "R6 zero-length DATA1");
    tok(K_IN);
    chk("R6 stage held", stage, 3);
    tok(K_ACK);
    chk("R6 complete stage", stage, 0);
    chk("R6 complete irq", ep0_irq, 1);

    // Stall and abort on a read transfer
    req_dir_in = 1'b1;
    tok(K_SETUP);
    stall_en = 1'b1;
    expect_tx(P_STALL, 1'b0, "R8 STALL");
    tok(K_IN);
    chk("R8 stage kept", stage, 1);
    tok(K_SETUP);
    chk("R8 setup accepted", ep0_irq, 1);
    stall_en = 1'b0;
    expect_tx(P_D1, 1'b0, "R3 IN after stall");
    tok(K_IN);
    tok(K_SETUP);
    chk("R1 abort stage", stage, 1);
    chk("R1 abort toggle", toggle, 1);
    tok(K_ACK);
    chk("R3 ACK after abort", toggle, 1);

    // Write with no data stage
    req_dir_in = 1'b0; req_has_data = 1'b0;
    tok(K_SETUP);
    tok(K_OUT);
    chk("R5 OUT ignored", tx_req, 0);
    chk("R5 stage kept", stage, 1);
    expect_tx(P_NAK, 1'b0, "R6 NAK without eop");
    tok(K_IN);
    chk("R5 no-data status", stage, 3);
    eop_pulse();
    expect_tx(P_D1, 1'b1, "R6 no-data ZLP");
    tok(K_IN);
    tok(K_ACK);
    chk("R6 no-data done", stage, 0);

    repeat (3) @(negedge clk);
    chk("R10 all expected sent", q_pid.size(), 0);
    finish_run();
  end
endmodule